// File: doc/BRIEF.md
# Cascaded Multipath Replica Canceller

This block sits between the filtered receiver samples and a small group of code tracking loops. In each sample it removes locally generated replica codes from the incoming value. The line-of-sight loop supplies one replica. Subtracting it from the input gives a residual in which the delayed reflection dominates, and that residual drives the multipath loop. The multipath loop supplies a second replica. That replica is scaled by an estimated reflection amplitude and subtracted from the original input. The result is a cleaned stream for the navigation loop, whose code drives the pseudorange measurement.

A multipath monitor requests the cascade when it judges the reflections significant. Without that request the block runs as a plain pass-through for a single loop: the navigation stream carries the raw input and the multipath stream is held at zero. A request takes effect only on the sample flagged as the first sample of a code period. An integration window therefore never mixes the two modes. Each replica is a ±1 chip scaled to a programmable magnitude. All arithmetic is signed and saturating, and the outputs are registered with one cycle of latency.

Top module: `mpc_canceller`

## Requirements
- R1: After reset, out_valid, cascade_on, res_mp and res_nav are all zero.
- R2: out_valid is high exactly one cycle after a cycle with smp_valid high. While smp_valid is low, res_mp, res_nav and cascade_on hold their values.
- R3: In cascade mode, res_mp = sat(r − s_los·REP_MAG). A chip input of 0 means s = +1 and a chip input of 1 means s = −1.
- R4: In cascade mode, res_nav = sat(r − s_mp·floor(REP_MAG·amp_mp/256)). amp_mp is an unsigned fraction in units of 1/256.
- R5: Results outside the W-bit signed range clamp to −2^(W−1) or 2^(W−1)−1.
- R6: In bypass mode, res_nav equals r and res_mp is zero, whatever the chip and amplitude inputs are.
- R7: The mode changes only on a valid sample with epoch_start high. That sample and every later one use cascade_req as sampled then. A change of cascade_req at any other time has no effect.
- R8: cascade_on reports the mode applied to the sample currently on res_mp and res_nav.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_r | input | W | Filtered incoming sample, signed |
| epoch_start | input | 1 | Marks the first sample of a code period |
| cascade_req | input | 1 | Cascade request from the multipath monitor |
| chip_los | input | 1 | Line-of-sight replica chip (0 = +1, 1 = −1) |
| chip_mp | input | 1 | Multipath replica chip (0 = +1, 1 = −1) |
| amp_mp | input | 8 | Multipath amplitude estimate, unsigned, units of 1/256 |
| out_valid | output | 1 | Output sample strobe |
| res_mp | output | W | Residual for the multipath loop |
| res_nav | output | W | Residual for the navigation loop |
| cascade_on | output | 1 | Mode applied to the current output sample |

## Verification
The input is swept across its whole signed range in coarse steps that include both extreme values. At each point the sweep runs all four chip-sign combinations and a set of amplitudes: zero, one LSB, one half, an arbitrary value and the maximum. This separates sign handling from scaling and truncation, and the extreme inputs paired with opposing chips expose missing or one-sided saturation. The same sweep is run in bypass mode to confirm that the chips and the amplitude have no effect there. A separate sequence changes the request between epochs and also drops the sample strobe. It distinguishes a mode change that waits for the period boundary from one that follows the request at once, and it shows whether the outputs hold when the strobe is low.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    // Replica chip encoding: 0 is a +1 chip, 1 is a -1 chip
    typedef enum logic {
        CHIP_POS = 1'b0,
        CHIP_NEG = 1'b1
    } chip_e;

    localparam int AMP_W   = 8;   // amplitude estimate width, units of 1/256
    localparam int SCALE_W = 9;   // scale width, enough to hold unity (256)
    localparam int NPATH   = 2;   // replica paths: 0 line of sight, 1 multipath
endpackage

// File: rtl/mpc_term.sv
// Scaled replica term: +/- floor(REP_MAG * scale / 256)
module mpc_term
    import mpc_pkg::*;
#(
    parameter int W       = 12,
    parameter int REP_MAG = 512
) (
    input  logic                 chip,
    input  logic [SCALE_W-1:0]   scale,
    output logic signed [W+1:0]  term
);
    localparam int PW = W + SCALE_W + 1;

    logic [PW-1:0] prod;
    logic [W:0]    mag;

    always_comb begin
        prod = PW'(REP_MAG) * {{(PW-SCALE_W){1'b0}}, scale};
        mag  = prod[W+8:8];
        if (chip_e'(chip) == CHIP_NEG) begin
            term = -$signed({1'b0, mag});
        end else begin
            term = $signed({1'b0, mag});
        end
    end

    logic unused_hi;
    assign unused_hi = ^prod[PW-1:W+9] ^ ^prod[7:0];
endmodule

// File: rtl/mpc_satsub.sv
// Saturating signed subtraction y = sat(a - b)
module mpc_satsub #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W+1:0] b,
    output logic signed [W-1:0] y
);
    localparam int DW = W + 3;
    localparam logic signed [DW-1:0] MAXV = DW'((2 ** (W - 1)) - 1);
    localparam logic signed [DW-1:0] MINV = -MAXV - DW'(1);

    logic signed [DW-1:0] diff;

    always_comb begin
        diff = $signed({{3{a[W-1]}}, a}) - $signed({b[W+1], b});
        if (diff > MAXV) begin
            y = MAXV[W-1:0];
        end else if (diff < MINV) begin
            y = MINV[W-1:0];
        end else begin
            y = diff[W-1:0];
        end
    end
endmodule

// File: rtl/mpc_mode.sv
// Cascade enable, changed only on the first sample of a code period
module mpc_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic epoch_start,
    input  logic cascade_req,
    output logic mode_now
);
    logic mode_d, mode_q;

    always_comb begin
        mode_now = (smp_valid && epoch_start) ? cascade_req : mode_q;
        mode_d   = mode_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    // R7: outside an epoch-marked sample the mode does not move
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && epoch_start) |=> $stable(mode_q));
endmodule

// File: rtl/mpc_canceller.sv
module mpc_canceller
    import mpc_pkg::*;
#(
    parameter int W       = 12,
    parameter int REP_MAG = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic signed [W-1:0] smp_r,
    input  logic                epoch_start,
    input  logic                cascade_req,
    input  logic                chip_los,
    input  logic                chip_mp,
    input  logic [AMP_W-1:0]    amp_mp,
    output logic                out_valid,
    output logic signed [W-1:0] res_mp,
    output logic signed [W-1:0] res_nav,
    output logic                cascade_on
);
    localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(256);

    typedef struct packed {
        logic                vld;
        logic                mode;
        logic signed [W-1:0] mp;
        logic signed [W-1:0] nav;
    } state_t;

    state_t st_d, st_q;
    logic   mode_now;

    logic               chips  [NPATH];
    logic [SCALE_W-1:0] scales [NPATH];
    logic signed [W+1:0] terms [NPATH];
    logic signed [W-1:0] diffs [NPATH];

    assign chips[0]  = chip_los;
    assign chips[1]  = chip_mp;
    assign scales[0] = UNITY;
    assign scales[1] = {1'b0, amp_mp};

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        mpc_term #(.W(W), .REP_MAG(REP_MAG)) i_term (
            .chip  (chips[p]),
            .scale (scales[p]),
            .term  (terms[p])
        );
        mpc_satsub #(.W(W)) i_sub (
            .a (smp_r),
            .b (terms[p]),
            .y (diffs[p])
        );
    end

    mpc_mode i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .epoch_start (epoch_start),
        .cascade_req (cascade_req),
        .mode_now    (mode_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_valid;
        if (smp_valid) begin
            st_d.mode = mode_now;
            st_d.mp   = mode_now ? diffs[0] : '0;
            st_d.nav  = mode_now ? diffs[1] : smp_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign res_mp     = st_q.mp;
    assign res_nav    = st_q.nav;
    assign cascade_on = st_q.mode;

    // R2: one cycle of latency
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    // R2: outputs hold while no sample arrives
    a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!out_valid && $stable(res_nav) && $stable(res_mp)));
    // R6: bypass passes the sample straight through
    a_r6_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !mode_now |=> (res_nav == $past(smp_r) && res_mp == '0));
    // R8: reported mode follows the enable in use for that sample
    a_r8_mode_report: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (cascade_on == $past(mode_now)));
endmodule

// File: tb/test_mpc_canceller.sv
module test_mpc_canceller;
    localparam int W       = 12;
    localparam int REP_MAG = 512;
    localparam int MAXV    = (2 ** (W - 1)) - 1;
    localparam int MINV    = -(2 ** (W - 1));

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic signed [W-1:0] smp_r = '0;
    logic                epoch_start = 1'b0;
    logic                cascade_req = 1'b0;
    logic                chip_los = 1'b0;
    logic                chip_mp = 1'b0;
    logic [7:0]          amp_mp = '0;
    logic                out_valid;
    logic signed [W-1:0] res_mp;
    logic signed [W-1:0] res_nav;
    logic                cascade_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_mode = 1'b0;

    always #2.5 clk = ~clk;

    mpc_canceller #(.W(W), .REP_MAG(REP_MAG)) i_mpc_canceller (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_r(smp_r),
        .epoch_start(epoch_start), .cascade_req(cascade_req),
        .chip_los(chip_los), .chip_mp(chip_mp), .amp_mp(amp_mp),
        .out_valid(out_valid), .res_mp(res_mp), .res_nav(res_nav),
        .cascade_on(cascade_on)
    );

    function automatic int sat(input int x);
        if (x > MAXV) return MAXV;
        if (x < MINV) return MINV;
        return x;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one sample at a falling edge, check the registered result one cycle later
    task automatic sample(input int r, input bit cl, input bit cm, input int a,
                          input bit ep, input bit req);
        int sl, sm, exp_mp, exp_nav;
        smp_valid = 1'b1; smp_r = W'(r); chip_los = cl; chip_mp = cm;
        amp_mp = 8'(a); epoch_start = ep; cascade_req = req;
        if (ep) model_mode = req;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0; epoch_start = 1'b0;
        sl = cl ? -1 : 1;
        sm = cm ? -1 : 1;
        if (model_mode) begin
            exp_mp  = sat(r - sl * REP_MAG);
            exp_nav = sat(r - sm * ((REP_MAG * a) / 256));
        end else begin
            exp_mp  = 0;
            exp_nav = r;
        end
        check("R2 out_valid", int'(out_valid), 1);
        check("R8 cascade_on", int'(cascade_on), int'(model_mode));
        check(model_mode ? "R3 res_mp" : "R6 res_mp bypass", int'(res_mp), exp_mp);
        check(model_mode ? "R4 res_nav" : "R6 res_nav bypass", int'(res_nav), exp_nav);
    endtask

    task automatic sweep(input bit mode);
        int amps [5] = '{0, 1, 128, 201, 255};
        sample(0, 0, 0, 0, 1'b1, mode);
        for (int r = MINV; r <= MAXV; r += 97) begin
            for (int c = 0; c < 4; c++) begin
                for (int k = 0; k < 5; k++) begin
                    sample(r, c[0], c[1], amps[k], 1'b0, ~mode);
                end
            end
        end
        for (int c = 0; c < 4; c++) begin
            sample(MAXV, c[0], c[1], 255, 1'b0, ~mode);
            sample(MINV, c[0], c[1], 255, 1'b0, ~mode);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 cascade_on", int'(cascade_on), 0);
        check("R1 res_mp", int'(res_mp), 0);
        check("R1 res_nav", int'(res_nav), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: bypass sweep, chips and amplitude have no effect
        sweep(1'b0);
        // R3 R4: cascade sweep
        sweep(1'b1);

        // R5: explicit saturation corners
        sample(MINV, 0, 0, 0, 1'b0, 1'b1);
        check("R5 low clamp", int'(res_mp), MINV);
        sample(MAXV, 1, 1, 255, 1'b0, 1'b1);
        check("R5 high clamp mp", int'(res_mp), MAXV);
        check("R5 high clamp nav", int'(res_nav), MAXV);

        // R7: request drop away from an epoch is ignored
        sample(100, 0, 1, 64, 1'b0, 1'b0);
        check("R7 req ignored", int'(cascade_on), 1);
        check("R7 req ignored mp", int'(res_mp), 100 - REP_MAG);
        // R7: takes effect on the epoch-marked sample itself
        sample(100, 0, 1, 64, 1'b1, 1'b0);
        check("R7 epoch switch", int'(cascade_on), 0);
        sample(-300, 1, 0, 64, 1'b0, 1'b1);
        check("R7 stays bypass", int'(res_nav), -300);

        // R2: outputs hold while the strobe is low
        smp_r = W'(555); cascade_req = 1'b1; chip_mp = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 no valid", int'(out_valid), 0);
        check("R2 hold nav", int'(res_nav), -300);
        check("R2 hold mode", int'(cascade_on), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule